// File: doc/BRIEF.md
# Sequencer Program RAM Loader

This block is the host-side loading port for the instruction memory of an embedded sequencer. The host reaches the memory through a small group of byte-wide registers. A control register enables loading and carries the sequencer reset, single-step and fast-mode controls. Two address registers together hold a 9-bit word address. One data window register moves bytes into and out of the addressed 32-bit instruction word.

To load the memory, the host first sets the load-enable bit and writes the start address. It then writes each instruction as four bytes to the data window, least significant byte first. The fourth byte commits the whole word to the RAM and advances the word address by one, so a program can be streamed in without rewriting the address. Reading the data window returns the addressed word one byte at a time and steps through the lanes and words in the same way. A separate registered fetch port gives the sequencer core read access to the array.

Top module: `seqram_loader`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, both address registers read 0x00, and the byte-lane counter sits at lane 0.
- R2: The control register at offset 0x060 keeps bit 0 (load enable, 0x01), bit 1 (sequencer reset, 0x02), bit 2 (single step, 0x04) and bit 4 (fast mode, 0x10). Every other bit reads back as 0. Bits 1, 2 and 4 drive `seq_reset`, `seq_step` and `seq_fast`.
- R3: While load enable is set, four writes to the data window at offset 0x061 build one word, with the first byte in bits 7:0 and the fourth in bits 31:24. The word is written to RAM when the fourth byte arrives, at the current word address.
- R4: The word address stays unchanged during the first three byte writes of a word. It increments by one after the fourth, wrapping from 511 to 0.
- R5: A data window write while load enable is clear changes neither the RAM, the address nor the byte lane.
- R6: The low address byte is at offset 0x062. Bit 0 of the register at offset 0x063 is address bit 8. A write to either register returns the byte lane to 0. Bits 7:1 of offset 0x063 read back as 0.
- R7: A data window read returns byte `lane` (lane 0 = bits 7:0) of the addressed word. It then advances the lane, and after lane 3 it moves to the next word address.
- R8: A control register write with bit 1 set clears the word address and the byte lane to 0.
- R9: `host_rdata` takes the read value on the clock edge that samples `host_rd`. `fetch_data` shows the word at `fetch_addr` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 10 | Register offset of the host access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access (a write in the same cycle wins) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| fetch_addr | input | 9 | Sequencer fetch word address |
| fetch_data | output | 32 | Registered fetch word |
| seq_reset | output | 1 | Sequencer reset control bit |
| seq_step | output | 1 | Single-step control bit |
| seq_fast | output | 1 | Fast-mode control bit |

## Verification
The hardest states to reach from the ports are those where the lane counter is partway through a word when something else happens. Examples are an address write, a reset-bit write, gated writes with load enable clear, and the wrap from address 511 to 0. None of these is visible directly, because the lane is internal. The stimulus therefore leaves partial words behind on purpose: it writes one to three stray bytes, or issues ignored writes, before the interrupting access. It then writes a full word, and the check is the address at which that word lands and its byte order, read through the fetch port and the window. Random address-and-word sequences from a fixed seed, including stray bytes before the address write, cover the remaining mix.

// File: rtl/seqram_pkg.sv
// Shared definitions for the sequencer program RAM loader.
// Assumes byte-wide host registers and a word width that is a multiple of 8.
package seqram_pkg;
    // Control register bit positions
    localparam int CTL_LOAD = 0;
    localparam int CTL_RST  = 1;
    localparam int CTL_STEP = 2;
    localparam int CTL_FAST = 4;
    localparam logic [7:0] CTL_MASK = 8'h17;

    // Decoded host register strobes
    typedef struct packed {
        logic ctrl_wr;
        logic ctrl_rd;
        logic data_wr;
        logic data_rd;
        logic alo_wr;
        logic alo_rd;
        logic ahi_wr;
        logic ahi_rd;
    } regsel_t;
endpackage

// File: rtl/seqram_regdec.sv
// Host register decode: turns offset plus strobes into one-hot register selects.
// Assumes at most one access per cycle; a write in the same cycle as a read wins.
module seqram_regdec
    import seqram_pkg::*;
#(
    parameter int REG_AW = 10,
    parameter logic [REG_AW-1:0] REG_BASE = 10'h060
) (
    input  logic [REG_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    output regsel_t           sel
);
    localparam logic [REG_AW-1:0] A_CTRL = REG_BASE;
    localparam logic [REG_AW-1:0] A_DATA = REG_BASE + REG_AW'(1);
    localparam logic [REG_AW-1:0] A_ALO  = REG_BASE + REG_AW'(2);
    localparam logic [REG_AW-1:0] A_AHI  = REG_BASE + REG_AW'(3);

    logic rd_ok;
    assign rd_ok = host_rd & ~host_wr;

    // Address match per register, gated by the strobe
    always_comb begin
        sel.ctrl_wr = host_wr & (host_addr == A_CTRL);
        sel.ctrl_rd = rd_ok   & (host_addr == A_CTRL);
        sel.data_wr = host_wr & (host_addr == A_DATA);
        sel.data_rd = rd_ok   & (host_addr == A_DATA);
        sel.alo_wr  = host_wr & (host_addr == A_ALO);
        sel.alo_rd  = rd_ok   & (host_addr == A_ALO);
        sel.ahi_wr  = host_wr & (host_addr == A_AHI);
        sel.ahi_rd  = rd_ok   & (host_addr == A_AHI);
    end
endmodule

// File: rtl/seqram_lane_ctr.sv
// Word address and byte-lane counter.
// The lane steps on each advance; after the last lane the word address increments.
// Assumes 9 <= ADDR_W <= 16 (low byte plus an upper register).
module seqram_lane_ctr #(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              advance,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] addr,
    output logic [LANE_W-1:0] lane,
    output logic              last_lane
);
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

    assign last_lane = (lane == LAST);

    // Address/lane update: clear, then address loads, then advance
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '0;
            lane <= '0;
        end else if (load_lo) begin
            addr[7:0] <= wdata;
            lane      <= '0;
        end else if (load_hi) begin
            addr[ADDR_W-1:8] <= wdata[ADDR_W-9:0];
            lane             <= '0;
        end else if (advance) begin
            if (last_lane) begin
                lane <= '0;
                addr <= addr + ADDR_W'(1);
            end else begin
                lane <= lane + LANE_W'(1);
            end
        end
    end
endmodule

// File: rtl/seqram_word_asm.sv
// Word assembly and byte selection.
// Holds the lower lanes of the word being loaded; the top lane comes straight
// from the write data so the word can commit in the cycle of the last byte.
module seqram_word_asm #(
    parameter int WORD_W = 32,
    localparam int LANES  = WORD_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wdata,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] full_word,
    output logic [7:0]        rd_byte
);
    logic [7:0] hold [LANES-1];

    for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
        // Capture the byte written to lane i
        always_ff @(posedge clk) begin
            if (!rst_n) hold[i] <= '0;
            else if (byte_we && lane == LANE_W'(i)) hold[i] <= wdata;
        end
        assign full_word[i*8 +: 8] = hold[i];
    end
    assign full_word[WORD_W-1 -: 8] = wdata;

    // Pick the current lane of the addressed word for a host read
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < LANES; i++)
            if (lane == LANE_W'(i)) rd_byte = rd_word[i*8 +: 8];
    end
endmodule

// File: rtl/seqram_array.sv
// Instruction RAM: one write port, an asynchronous host read port and a
// registered fetch port for the sequencer. Contents are not reset.
module seqram_array #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Commit a whole word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // Registered fetch for the sequencer core
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_data <= '0;
        else        fetch_data <= mem[fetch_addr];
    end
endmodule

// File: rtl/seqram_loader.sv
// Sequencer program RAM loader (top).
// The host loads and reads instruction words through a byte-wide data window.
// Assumes single-cycle read/write strobes, with at most one access per cycle.
module seqram_loader
    import seqram_pkg::*;
#(
    parameter int REG_AW = 10,
    parameter logic [REG_AW-1:0] REG_BASE = 10'h060,
    parameter int ADDR_W = 9,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_data,
    output logic              seq_reset,
    output logic              seq_step,
    output logic              seq_fast
);
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);

    regsel_t           sel;
    logic [7:0]        ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANE_W-1:0] lane_q;
    logic              last_lane;
    logic              byte_wr;
    logic              commit;
    logic [WORD_W-1:0] full_word;
    logic [WORD_W-1:0] host_word;
    logic [7:0]        rd_byte;
    logic [7:0]        rd_mux;
    logic              any_rd;

    seqram_regdec #(.REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_dec (
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd), .sel(sel)
    );

    // Control register, only the defined bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n)          ctrl_q <= '0;
        else if (sel.ctrl_wr) ctrl_q <= host_wdata & CTL_MASK;
    end

    assign seq_reset = ctrl_q[CTL_RST];
    assign seq_step  = ctrl_q[CTL_STEP];
    assign seq_fast  = ctrl_q[CTL_FAST];
    assign byte_wr   = sel.data_wr & ctrl_q[CTL_LOAD];
    assign commit    = byte_wr & last_lane;

    seqram_lane_ctr #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .clear(sel.ctrl_wr & host_wdata[CTL_RST]),
        .load_lo(sel.alo_wr), .load_hi(sel.ahi_wr),
        .advance(byte_wr | sel.data_rd),
        .wdata(host_wdata),
        .addr(addr_q), .lane(lane_q), .last_lane(last_lane)
    );

    seqram_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_wr), .lane(lane_q),
        .wdata(host_wdata), .rd_word(host_word),
        .full_word(full_word), .rd_byte(rd_byte)
    );

    seqram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(addr_q), .wdata(full_word),
        .raddr(addr_q), .rdata(host_word),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    // Read-data selection by register
    always_comb begin
        rd_mux = '0;
        if (sel.ctrl_rd) rd_mux = ctrl_q;
        if (sel.data_rd) rd_mux = rd_byte;
        if (sel.alo_rd)  rd_mux = addr_q[7:0];
        if (sel.ahi_rd)  rd_mux[ADDR_W-9:0] = addr_q[ADDR_W-1:8];
    end
    assign any_rd = sel.ctrl_rd | sel.data_rd | sel.alo_rd | sel.ahi_rd;

    // Register the read data on a mapped read
    always_ff @(posedge clk) begin
        if (!rst_n)      host_rdata <= '0;
        else if (any_rd) host_rdata <= rd_mux;
    end
endmodule

// File: rtl/seqram_loader_chk.sv
// Property checker for the program RAM loader, bound to the top module.
// Decodes the host strobes on its own and watches the address and lane state.
module seqram_loader_chk #(
    parameter int REG_AW = 10,
    parameter logic [REG_AW-1:0] REG_BASE = 10'h060,
    parameter int ADDR_W = 9,
    parameter int LANE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic [7:0]        ctrl,
    input logic [ADDR_W-1:0] addr,
    input logic [LANE_W-1:0] lane
);
    localparam logic [LANE_W-1:0] LAST = '1;
    logic dwr;
    assign dwr = host_wr && host_addr == REG_BASE + REG_AW'(1);

    // R5
    ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && !ctrl[0]) |=> ($stable(addr) && $stable(lane)));

    // R4
    lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && ctrl[0] && lane != LAST) |=>
            (addr == $past(addr) && lane == $past(lane) + LANE_W'(1)));

    // R4
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && ctrl[0] && lane == LAST) |=>
            (lane == '0 && addr == $past(addr) + ADDR_W'(1)));

    // R6
    addr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_BASE + REG_AW'(2)) |=>
            (lane == '0 && addr[7:0] == $past(host_wdata)));

    // R8
    seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_BASE && host_wdata[1]) |=>
            (addr == '0 && lane == '0));

    // R6
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == REG_BASE + REG_AW'(3)) |=>
            (host_rdata[7:ADDR_W-8] == '0));
endmodule

bind seqram_loader seqram_loader_chk #(
    .REG_AW(REG_AW), .REG_BASE(REG_BASE), .ADDR_W(ADDR_W), .LANE_W(LANE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctrl(ctrl_q), .addr(addr_q), .lane(lane_q)
);

// File: tb/sim_seqram_loader.sv
// Bench for the program RAM loader: directed corners plus seeded random loads,
// checked against a bench-side model of the memory, address and lane.
module sim_seqram_loader;
    localparam logic [9:0] A_CTRL = 10'h060;
    localparam logic [9:0] A_DATA = 10'h061;
    localparam logic [9:0] A_ALO  = 10'h062;
    localparam logic [9:0] A_AHI  = 10'h063;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [8:0]  fetch_addr = '0;
    logic [31:0] fetch_data;
    logic        seq_reset, seq_step, seq_fast;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Bench model
    logic [31:0] m_mem [512];
    bit          m_ok  [512];
    int          m_addr = 0, m_lane = 0;
    bit          m_load = 1'b0;
    logic [7:0]  m_part [4];

    always #5 clk = ~clk;

    seqram_loader u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .seq_reset(seq_reset), .seq_step(seq_step), .seq_fast(seq_fast)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
        return {b3, b2, b1, b0};
    endfunction

    // Model-tracked accesses
    task automatic set_ctrl(input logic [7:0] d);
        reg_wr(A_CTRL, d);
        m_load = d[0];
        if (d[1]) begin m_addr = 0; m_lane = 0; end
    endtask

    task automatic set_addr(input int a);
        reg_wr(A_ALO, a[7:0]);
        reg_wr(A_AHI, {7'h55, a[8]});
        m_addr = a; m_lane = 0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        reg_wr(A_DATA, b);
        if (m_load) begin
            m_part[m_lane] = b;
            if (m_lane == 3) begin
                m_mem[m_addr] = pack4(m_part[0], m_part[1], m_part[2], m_part[3]);
                m_ok[m_addr] = 1'b1;
                m_lane = 0; m_addr = (m_addr + 1) % 512;
            end else m_lane++;
        end
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) put_byte(w[i*8 +: 8]);
    endtask

    task automatic fetch(input int a, output logic [31:0] w);
        @(negedge clk);
        fetch_addr = a[8:0];
        @(negedge clk);
        w = fetch_data;
    endtask

    task automatic read_addr(output int a);
        logic [7:0] lo, hi;
        reg_rd(A_ALO, lo);
        reg_rd(A_AHI, hi);
        a = {hi[0], lo};
    endtask

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        int          a;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(A_CTRL, b); chk("R1 ctrl", b, 8'h00);
        read_addr(a);      chk("R1 addr", a, 0);

        // R2 control bits and outputs
        reg_wr(A_CTRL, 8'hFD);
        reg_rd(A_CTRL, b); chk("R2 ctrl mask", b, 8'h15);
        chk("R2 outputs", {seq_reset, seq_step, seq_fast}, 3'b011);
        set_ctrl(8'h02);
        chk("R2 reset out", seq_reset, 1'b1);
        set_ctrl(8'h01);

        // R6 upper bits zero, R4 wrap from 511
        set_addr(511);
        reg_rd(A_AHI, b); chk("R6 hi readback", b, 8'h01);
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
        read_addr(a); chk("R4 hold mid-word", a, 511);
        put_byte(8'h44);
        read_addr(a); chk("R4 wrap", a, 0);
        fetch(511, w); chk("R3 byte order", w, 32'h44332211);

        // R5 gated writes leave lane and RAM alone
        set_ctrl(8'h00);
        put_byte(8'hE1); put_byte(8'hE2);
        set_ctrl(8'h01);
        put_word(32'hA5A5_0F0F);
        fetch(0, w); chk("R5 ignored writes", w, 32'hA5A5_0F0F);
        read_addr(a); chk("R5 address after", a, 1);

        // R6 address write drops a partial word
        put_byte(8'hBB); put_byte(8'hCC);
        set_addr(5);
        put_word(32'hDEAD_BEEF);
        fetch(5, w); chk("R6 lane reset", w, 32'hDEAD_BEEF);

        // R7 window read back
        set_addr(5);
        w = '0;
        for (int i = 0; i < 4; i++) begin reg_rd(A_DATA, b); w[i*8 +: 8] = b; end
        chk("R7 window read", w, 32'hDEAD_BEEF);
        read_addr(a); chk("R7 address advance", a, 6);

        // R8 reset bit clears address and lane mid-word
        put_byte(8'h77);
        set_ctrl(8'h03);
        read_addr(a); chk("R8 clear address", a, 0);
        set_ctrl(8'h01);
        put_word(32'h0102_0304);
        fetch(0, w); chk("R8 clear lane", w, 32'h0102_0304);

        // Random loads with stray bytes before the address write (R3 R4 R6)
        for (int n = 0; n < 150; n++) begin
            int ra = $urandom % 512;
            int stray = $urandom % 4;
            for (int s = 0; s < stray; s++) put_byte(8'($urandom));
            set_addr(ra);
            put_word($urandom);
            if (n % 15 == 0) begin
                read_addr(a); chk("R4 random address", a, (ra + 1) % 512);
            end
        end
        // Verify through fetch (R3, R9) and window (R7)
        for (int n = 0; n < 40; n++) begin
            int ra = $urandom % 512;
            if (m_ok[ra]) begin
                fetch(ra, w); chk("R3 random fetch", w, m_mem[ra]);
            end
        end
        for (int n = 0; n < 10; n++) begin
            int ra = $urandom % 512;
            if (m_ok[ra]) begin
                set_addr(ra);
                w = '0;
                for (int i = 0; i < 4; i++) begin reg_rd(A_DATA, b); w[i*8 +: 8] = b; end
                chk("R7 random window", w, m_mem[ra]);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule